// File: doc/BRIEF.md
# Multiplexed ADC Sequencing Controller

This block runs an external 8-bit converter that has a built-in 8-input analog multiplexer from ordinary synchronous logic. It makes the converter's clock by dividing the system clock. For each channel it puts the channel address on three select lines, strobes the address latch, and sends a start pulse. It then waits for the converter's busy signal to fall and rise again, pulses the output enable and captures the result byte.

Channels `0` to `NUM_CH-1` are visited in ascending order and the sequence wraps back to channel 0. Each captured byte is announced with a one-cycle strobe that carries its channel number, and the byte is also kept in a per-channel result register. A level enable gates the scan. A watchdog stops the sequence and raises a sticky flag when the converter stops answering.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the controller to idle. `ale`, `start`, `oe`, `adc_clk`, `data_valid`, `timeout` and `results` are all 0 while reset is held.
- R2: `adc_clk` is the system clock divided by `2*HALF_DIV`. It is high for `HALF_DIV` system clocks and low for `HALF_DIV` system clocks.
- R3: `addr[2:0]` carries the channel index, with bit 2 as the most significant select line. Conversions use channels 0, 1, ..., `NUM_CH-1` in that order and then wrap to 0. With the default `NUM_CH`=4, bit 2 is always 0.
- R4: `ale` stays high for at least one full converter clock period (`2*HALF_DIV` system clocks).
- R5: `start` rises only after `ale` has been low for at least one converter clock period. It then stays high for at least one converter clock period, so the converter sees a complete high-then-low pulse.
- R6: `addr` stays unchanged from the rise of `ale` until the result of that conversion has been captured.
- R7: After `eoc` rises, `oe` goes high on the third rising system clock edge, and stays high for exactly one system clock. The count of three edges includes the two-flop synchronizer.
- R8: The byte present on `adc_data` while `oe` is high is captured. When `oe` falls, `data_valid` is high for one cycle, with the byte on `data_out` and its channel on `data_ch`. The same byte is written to `results[8*ch +: 8]`.
- R9: While `scan_en` is low, no new conversion is begun: `ale` stays low once the current conversion has finished.
- R10: If `eoc` fails to fall after a start pulse, or fails to rise after falling, within `TIMEOUT` converter clocks, the controller stops. `timeout` goes high and stays high until reset, and `ale`, `start` and `oe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Allows new conversions to begin |
| eoc | input | 1 | Converter busy/done line, asynchronous |
| adc_data | input | 8 | Converter result byte |
| adc_clk | output | 1 | Divided converter clock |
| addr | output | 3 | Multiplexer select; bit 2 is the most significant |
| ale | output | 1 | Address latch strobe |
| start | output | 1 | Conversion start pulse |
| oe | output | 1 | Converter output enable |
| data_valid | output | 1 | One-cycle strobe for a captured byte |
| data_out | output | 8 | Captured byte |
| data_ch | output | 3 | Channel of the captured byte |
| results | output | NUM_CH*8 | Last byte captured for each channel |
| timeout | output | 1 | Sticky watchdog flag |

## Verification
A wrong channel counter shows up on `addr` at the next latch strobe. It also shows up on `data_ch` when that conversion is captured, one conversion time (about 64 converter clocks) later. A state machine that skips or shortens a state changes the measured width of `ale` or `start` within the same converter period. A broken `eoc` handshake moves the `oe` pulse away from its fixed three-edge position, or it raises `timeout`. A mis-wired capture path puts the wrong byte into the scoreboard comparison on the very strobe that reports it.

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl #(
  parameter int HALF_DIV = 2,
  parameter int NUM_CH   = 4,
  parameter int TIMEOUT  = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_en,
  input  logic                eoc,
  input  logic [7:0]          adc_data,
  output logic                adc_clk,
  output logic [2:0]          addr,
  output logic                ale,
  output logic                start,
  output logic                oe,
  output logic                data_valid,
  output logic [7:0]          data_out,
  output logic [2:0]          data_ch,
  output logic [NUM_CH*8-1:0] results,
  output logic                timeout
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int WW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {IDLE, ALE_H, GAP, START_H, WFALL, WRISE, OE_H, ERR} st_t;

  st_t           st;
  logic [DW-1:0] div;
  logic [WW-1:0] wd;
  logic [2:0]    ch;
  logic          ph, s1, s2, s3;

  wire tick     = (div == DW'(HALF_DIV - 1)) && !adc_clk;
  wire eoc_rise = s2 && !s3;
  wire wd_full  = (wd == WW'(TIMEOUT));

  assign addr  = ch;
  assign ale   = (st == ALE_H);
  assign start = (st == START_H);
  assign oe    = (st == OE_H);

  always_ff @(posedge clk) begin
    if (rst) begin
      div     <= '0;
      adc_clk <= 1'b0;
    end else if (div == DW'(HALF_DIV - 1)) begin
      div     <= '0;
      adc_clk <= ~adc_clk;
    end else begin
      div <= div + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) {s1, s2, s3} <= 3'b111;
    else     {s1, s2, s3} <= {eoc, s1, s2};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      ph         <= 1'b0;
      wd         <= '0;
      ch         <= '0;
      data_valid <= 1'b0;
      data_out   <= '0;
      data_ch    <= '0;
      results    <= '0;
      timeout    <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      case (st)
        IDLE: if (scan_en) begin
          st <= ALE_H;
          ph <= 1'b0;
        end
        ALE_H, GAP, START_H: if (tick) begin
          ph <= ~ph;
          if (ph) begin
            wd <= '0;
            st <= (st == ALE_H) ? GAP : (st == GAP) ? START_H : WFALL;
          end
        end
        WFALL, WRISE: begin
          if ((st == WFALL && !s2) || (st == WRISE && eoc_rise)) begin
            st <= (st == WFALL) ? WRISE : OE_H;
            wd <= '0;
          end else if (wd_full) begin
            st      <= ERR;
            timeout <= 1'b1;
          end else if (tick) begin
            wd <= wd + 1'b1;
          end
        end
        OE_H: begin
          data_out                 <= adc_data;
          data_ch                  <= ch;
          data_valid               <= 1'b1;
          results[int'(ch)*8 +: 8] <= adc_data;
          ch                       <= (ch == 3'(NUM_CH - 1)) ? 3'd0 : ch + 3'd1;
          st                       <= IDLE;
        end
        default: st <= ERR;
      endcase
    end
  end

  a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (st != IDLE && $past(st) != IDLE) |-> $stable(addr));
  a_r7_oe_after_eoc: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (s2 && s3));
  a_r7_oe_single: assert property (@(posedge clk) disable iff (rst)
    oe |=> !oe);
  a_r8_valid_after_oe: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(oe));
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout |=> timeout);
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    timeout |-> (!ale && !start && !oe));
endmodule

// File: tb/adc_scan_ctrl_test.sv
`timescale 1ns/1ps
module adc_scan_ctrl_test;
  localparam int HD = 2, NCH = 4, TO = 100, PER = 20;

  logic clk = 0, rst = 1, scan_en = 0, eoc = 1;
  logic [7:0] adc_data = 0;
  logic adc_clk, ale, start, oe, data_valid, timeout;
  logic [2:0] addr, data_ch;
  logic [7:0] data_out;
  logic [NCH*8-1:0] results;

  adc_scan_ctrl #(.HALF_DIV(HD), .NUM_CH(NCH), .TIMEOUT(TO)) uut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .eoc(eoc), .adc_data(adc_data),
    .adc_clk(adc_clk), .addr(addr), .ale(ale), .start(start), .oe(oe),
    .data_valid(data_valid), .data_out(data_out), .data_ch(data_ch),
    .results(results), .timeout(timeout));

  always #(PER/2) clk = ~clk;

  int total = 0, fails = 0, exp_ch = 0, conv_n = 0, valid_n = 0, ale_rises = 0;
  bit hang = 0;
  time t_sfall = 0;
  logic [10:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge ale) ale_rises++;

  // converter model: pushes expected results into the scoreboard queue
  initial begin
    forever begin
      time t0, t1;
      logic [2:0] lat;
      logic [7:0] d;
      @(posedge ale); t0 = $time;
      lat = addr;
      @(negedge ale); t1 = $time;
      chk((t1 - t0) / PER >= 2*HD, "R4 ale width", int'((t1 - t0) / PER), 2*HD);
      chk(lat == 3'(exp_ch), "R3 channel order", lat, exp_ch);
      exp_ch = (exp_ch + 1) % NCH;
      @(posedge start); t0 = $time;
      chk((t0 - t1) / PER >= 2*HD, "R5 ale-start gap", int'((t0 - t1) / PER), 2*HD);
      @(negedge start); t_sfall = $time;
      chk((t_sfall - t0) / PER >= 2*HD, "R5 start width", int'((t_sfall - t0) / PER), 2*HD);
      if (!hang) begin
        @(negedge clk); @(negedge clk); eoc = 0;
        repeat (64) @(posedge adc_clk);
        @(negedge clk);
        d = 8'(int'(lat)*37 + conv_n*11 + 8'h5A);
        conv_n++;
        adc_data = d;
        exp_q.push_back({lat, d});
        chk(addr == lat, "R6 addr held", addr, lat);
        eoc = 1;
        @(negedge clk); chk(oe == 0, "R7 oe early", oe, 0);
        @(negedge clk); chk(oe == 0, "R7 oe early", oe, 0);
        @(negedge clk); chk(oe == 1, "R7 oe rise", oe, 1);
        @(negedge clk); chk(oe == 0, "R7 oe one cycle", oe, 0);
        chk(data_valid == 1, "R8 strobe", data_valid, 1);
      end
    end
  end

  // monitor: pops and compares
  always @(negedge clk) begin
    if (data_valid) begin
      valid_n++;
      if (exp_q.size() == 0) chk(0, "R8 unexpected strobe", 1, 0);
      else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(data_ch == e[10:8], "R8 channel", data_ch, e[10:8]);
        chk(data_out == e[7:0], "R8 byte", data_out, e[7:0]);
        chk(results[int'(data_ch)*8 +: 8] == e[7:0], "R8 result reg",
            results[int'(data_ch)*8 +: 8], e[7:0]);
      end
    end
  end

  task automatic check_reset_state(input string tag);
    chk({ale, start, oe, adc_clk, data_valid, timeout} == 6'b0, tag,
        {ale, start, oe, adc_clk, data_valid, timeout}, 0);
    chk(results == '0, tag, 32'(results), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state("R1 reset");
    rst = 0;
    repeat (30) @(negedge clk);
    chk(ale_rises == 0, "R9 idle while disabled", ale_rises, 0);
    begin
      time a, b, c;
      @(posedge adc_clk); a = $time;
      @(negedge adc_clk); b = $time;
      @(posedge adc_clk); c = $time;
      chk((c - a) / PER == 2*HD, "R2 period", int'((c - a) / PER), 2*HD);
      chk((b - a) / PER == HD, "R2 high time", int'((b - a) / PER), HD);
    end
    @(negedge clk); scan_en = 1;
    wait (valid_n == 6);
    @(posedge ale); @(negedge clk); scan_en = 0;
    wait (valid_n == 7);
    begin
      int r;
      r = ale_rises;
      repeat (300) @(negedge clk);
      chk(ale_rises == r, "R9 no new conversion", ale_rises, r);
      chk(valid_n == 7, "R9 no new strobe", valid_n, 7);
    end
    hang = 1;
    @(negedge clk); scan_en = 1;
    begin
      int n = 0;
      while (!timeout && n < 3000) begin @(negedge clk); n++; end
      chk(timeout == 1, "R10 timeout raised", timeout, 1);
      chk(($time - t_sfall) / PER >= TO*2*HD, "R10 not early",
          int'(($time - t_sfall) / PER), TO*2*HD);
      repeat (50) @(negedge clk);
      chk(timeout == 1, "R10 sticky", timeout, 1);
      chk({ale, start, oe} == 3'b0, "R10 quiet", {ale, start, oe}, 0);
    end
    rst = 1; scan_en = 0; hang = 0; exp_ch = 0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset clears");
    rst = 0; scan_en = 1;
    wait (valid_n == 9);
    @(negedge clk);
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule